// File: doc/BRIEF.md
# Hot-Plug Detect Routing Logic

This block produces the hot-plug indications presented to several source-side connector ports of a multi-input video switch. Each port output is derived either from the single hot-plug input coming back from the downstream sink, routed to whichever port is currently selected, or from a set of per-port bits written by configuration software. A stage-type input chooses how the level reaches the pin: as an open-drain pull-down that releases to an external pull-up, or as an always-driving inverting buffer stage.

Every port output is delivered as a drive value and a drive enable, so that both stage types are described with the same pair of signals. All outputs are registered. A change on any input appears at the pins exactly one clock later, so a port-selection change settles in a known, fixed time.

Top module: `hpd_route`

## Requirements
- R1: With `src_reg`=0 and `push_stage`=0, the port whose index equals `port_sel` (0, 1 or 2) carries the level of `sink_hpd`, and every other port carries a low level.
- R2: With `src_reg`=0 and `push_stage`=1, the port whose index equals `port_sel` carries the inverse of `sink_hpd`, and every other port carries a high level.
- R3: With `src_reg`=0 and `port_sel`=3 (no port selected), all ports carry a low level when `push_stage`=0 and a high level when `push_stage`=1, whatever `sink_hpd` is.
- R4: With `src_reg`=1 and `push_stage`=0, port i carries the level of `prog_bits[i]`; `port_sel` and `sink_hpd` have no effect on any output.
- R5: With `src_reg`=1 and `push_stage`=1, port i carries the inverse of `prog_bits[i]`; `port_sel` and `sink_hpd` have no effect on any output.
- R6: Pin encoding: when `push_stage`=0 a low level is `hpd_oe[i]`=1 with `hpd_val[i]`=0 and a high level is `hpd_oe[i]`=0 with `hpd_val[i]`=0; when `push_stage`=1, `hpd_oe[i]`=1 and `hpd_val[i]` equals the level.
- R7: Outputs reflect the inputs sampled at a rising clock edge starting at that same edge, and do not change between edges.
- R8: While `rst_n` is low at a rising edge, all outputs become `hpd_oe`=0 and `hpd_val`=0 (all lines released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sink_hpd | input | 1 | Hot-plug level from the downstream sink |
| port_sel | input | 2 | Selected port index; 3 selects none |
| src_reg | input | 1 | 0: route sink level, 1: use programmed bits |
| push_stage | input | 1 | 0: open-drain stage, 1: inverting buffer stage |
| prog_bits | input | 3 | Programmed per-port levels, bit i for port i |
| hpd_val | output | 3 | Drive value per port |
| hpd_oe | output | 3 | Drive enable per port |

## Verification
The embedded properties check on every cycle the pin encoding of both stage types, that at most one port is released in routed open-drain mode and at most one is driven low in routed buffer mode, that programmed mode follows the programmed bits against the previous cycle's inputs, and the all-low result when no port is selected. That `port_sel` and `sink_hpd` are ignored in programmed mode, the exact one-clock latency with no early change, and the reset state are shown only by the bench, which sweeps every combination of mode, stage, selection, sink level and programmed bits and compares each against an arithmetic model.

// File: rtl/hpd_route_pkg.sv
package hpd_route_pkg;

    // One physical pin as seen by the pad: value and enable.
    typedef struct packed {
        logic val;
        logic oe;
    } pin_drv_t;

    // Stage type selector values.
    localparam logic STAGE_OPEN_DRAIN = 1'b0;
    localparam logic STAGE_PUSH_INV   = 1'b1;

endpackage

// File: rtl/hpd_level_sel.sv
// Intended logical level of one source port, before pin encoding.
module hpd_level_sel #(
    parameter int PORT_IDX = 0,
    parameter int SEL_W    = 2
) (
    input  logic             sink_hpd,
    input  logic [SEL_W-1:0] port_sel,
    input  logic             src_reg,
    input  logic             push_stage,
    input  logic             prog_bit,
    output logic             level
);
    localparam logic [SEL_W-1:0] MY_CODE = SEL_W'(PORT_IDX);

    logic raw_lvl;

    always_comb begin
        if (src_reg) begin
            raw_lvl = prog_bit;
        end else if (port_sel == MY_CODE) begin
            raw_lvl = sink_hpd;
        end else begin
            raw_lvl = 1'b0;
        end
        // The buffer stage inverts every port.
        level = push_stage ? ~raw_lvl : raw_lvl;
    end

endmodule

// File: rtl/hpd_pin_drv.sv
// Maps an intended level onto value/enable for the chosen stage type.
module hpd_pin_drv
    import hpd_route_pkg::*;
(
    input  logic     level,
    input  logic     push_stage,
    output pin_drv_t drv
);
    always_comb begin
        if (push_stage == STAGE_PUSH_INV) begin
            drv.oe  = 1'b1;
            drv.val = level;
        end else begin
            drv.oe  = ~level;
            drv.val = 1'b0;
        end
    end

endmodule

// File: rtl/hpd_route.sv
module hpd_route
    import hpd_route_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sink_hpd,
    input  logic [$clog2(NUM_PORTS+1)-1:0] port_sel,
    input  logic                         src_reg,
    input  logic                         push_stage,
    input  logic [NUM_PORTS-1:0]         prog_bits,
    output logic [NUM_PORTS-1:0]         hpd_val,
    output logic [NUM_PORTS-1:0]         hpd_oe
);
    localparam int SEL_W = $clog2(NUM_PORTS + 1);

    typedef struct packed {
        logic [NUM_PORTS-1:0] val;
        logic [NUM_PORTS-1:0] oe;
    } out_t;

    pin_drv_t [NUM_PORTS-1:0] drv_w;
    logic     [NUM_PORTS-1:0] lvl_w;

    out_t out_d, out_q;
    logic past_ok_d, past_ok_q;

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
        hpd_level_sel #(
            .PORT_IDX (gi),
            .SEL_W    (SEL_W)
        ) u_lvl (
            .sink_hpd   (sink_hpd),
            .port_sel   (port_sel),
            .src_reg    (src_reg),
            .push_stage (push_stage),
            .prog_bit   (prog_bits[gi]),
            .level      (lvl_w[gi])
        );

        hpd_pin_drv u_drv (
            .level      (lvl_w[gi]),
            .push_stage (push_stage),
            .drv        (drv_w[gi])
        );
    end

    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            out_d.val[i] = drv_w[i].val;
            out_d.oe[i]  = drv_w[i].oe;
        end
        past_ok_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            past_ok_q <= 1'b0;
        end else begin
            out_q     <= out_d;
            past_ok_q <= past_ok_d;
        end
    end

    assign hpd_val = out_q.val;
    assign hpd_oe  = out_q.oe;

    // R6: open-drain stage never drives a one.
    a_r6_od_val_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(push_stage)) |-> (hpd_val == '0));

    // R6: buffer stage drives every port.
    a_r6_push_all_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(push_stage)) |-> (hpd_oe == '1));

    // R1: routed open-drain mode releases at most one port.
    a_r1_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(src_reg) && !$past(push_stage)) |-> $onehot0(~hpd_oe));

    // R2: routed buffer mode drives at most one port low.
    a_r2_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(src_reg) && $past(push_stage)) |-> ($countones(~hpd_val) <= 1));

    // R3: no port selected, open-drain: all pulled low.
    a_r3_none_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(src_reg) && !$past(push_stage)
         && ($past(port_sel) >= SEL_W'(NUM_PORTS))) |-> (hpd_oe == '1));

    // R4: programmed open-drain mode follows the programmed bits.
    a_r4_prog_od: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(src_reg) && !$past(push_stage)) |-> (hpd_oe == ~$past(prog_bits)));

    // R5: programmed buffer mode drives the inverted bits.
    a_r5_prog_push: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(src_reg) && $past(push_stage)) |-> (hpd_val == ~$past(prog_bits)));

endmodule

// File: tb/hpd_route_tb.sv
module hpd_route_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sink_hpd;
    logic [1:0] port_sel;
    logic       src_reg;
    logic       push_stage;
    logic [2:0] prog_bits;
    logic [2:0] hpd_val;
    logic [2:0] hpd_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hpd_route #(.NUM_PORTS(3)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sink_hpd   (sink_hpd),
        .port_sel   (port_sel),
        .src_reg    (src_reg),
        .push_stage (push_stage),
        .prog_bits  (prog_bits),
        .hpd_val    (hpd_val),
        .hpd_oe     (hpd_oe)
    );

    // Expected pin pair from the requirements.
    function automatic logic [5:0] model(input logic s, input logic [1:0] ps,
                                         input logic sr, input logic pp,
                                         input logic [2:0] pb);
        logic [2:0] lvl, v, e;
        for (int i = 0; i < 3; i++) begin
            if (sr) lvl[i] = pb[i];
            else    lvl[i] = (int'(ps) == i) ? s : 1'b0;
            if (pp) lvl[i] = 1'b1 - lvl[i];
            v[i] = pp ? lvl[i] : 1'b0;
            e[i] = pp ? 1'b1 : (1'b1 - lvl[i]);
        end
        return {v, e};
    endfunction

    task automatic check(input string tag, input logic [5:0] exp_ve);
        n_chk++;
        if ({hpd_val, hpd_oe} !== exp_ve) begin
            n_fail++;
            $display("FAIL %s: val/oe actual %b/%b expected %b/%b", tag,
                     hpd_val, hpd_oe, exp_ve[5:3], exp_ve[2:0]);
        end
    endtask

    task automatic drive(input logic s, input logic [1:0] ps, input logic sr,
                         input logic pp, input logic [2:0] pb);
        sink_hpd = s; port_sel = ps; src_reg = sr; push_stage = pp; prog_bits = pb;
    endtask

    function automatic string tag_of(input logic [1:0] ps, input logic sr, input logic pp);
        if (sr) return pp ? "R5" : "R4";
        if (ps == 2'd3) return "R3";
        return pp ? "R2" : "R1";
    endfunction

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 2'd0, 1'b0, 1'b1, 3'b101);
        repeat (2) @(posedge clk);
        #1 check("R8 reset", 6'b000_000);
        @(negedge clk) rst_n = 1'b1;

        // Exhaustive sweep (R1..R6 by category).
        for (int sr = 0; sr < 2; sr++)
            for (int pp = 0; pp < 2; pp++)
                for (int ps = 0; ps < 4; ps++)
                    for (int s = 0; s < 2; s++)
                        for (int pb = 0; pb < 8; pb++) begin
                            @(negedge clk);
                            drive(s[0], ps[1:0], sr[0], pp[0], pb[2:0]);
                            @(posedge clk); #1;
                            check(tag_of(ps[1:0], sr[0], pp[0]),
                                  model(s[0], ps[1:0], sr[0], pp[0], pb[2:0]));
                        end

        // R6: explicit encoding spot checks.
        @(negedge clk); drive(1'b1, 2'd1, 1'b0, 1'b0, 3'b000);
        @(posedge clk); #1 check("R6 od port1 released", 6'b000_101);
        @(negedge clk); drive(1'b1, 2'd1, 1'b0, 1'b1, 3'b000);
        @(posedge clk); #1 check("R6 push port1 low", 6'b101_111);

        // R4/R5: selection and sink changes ignored in programmed mode.
        for (int pp = 0; pp < 2; pp++) begin
            @(negedge clk); drive(1'b0, 2'd0, 1'b1, pp[0], 3'b110);
            @(posedge clk); #1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); drive(k[0], k[1:0], 1'b1, pp[0], 3'b110);
                @(posedge clk); #1;
                check(pp ? "R5 sel ignored" : "R4 sel ignored",
                      model(1'b0, 2'd0, 1'b1, pp[0], 3'b110));
            end
        end

        // R7: no change before the edge, new value right after it.
        @(negedge clk); drive(1'b1, 2'd2, 1'b0, 1'b0, 3'b000);
        @(posedge clk); #1;
        @(negedge clk); drive(1'b1, 2'd0, 1'b0, 1'b0, 3'b000);
        #3 check("R7 held before edge", model(1'b1, 2'd2, 1'b0, 1'b0, 3'b000));
        @(posedge clk); #1 check("R7 updated after edge", model(1'b1, 2'd0, 1'b0, 1'b0, 3'b000));

        // R8: reset mid-run releases everything.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 check("R8 reset mid-run", 6'b000_000);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule